// File: doc/BRIEF.md
# Configurable Serial Receiver with Error Flags

This block turns a serial receive line into parallel words. It uses a receive-clock strobe, and that strobe is divided by 1, 16 or 64 to give the bit timing. In the two divided modes, a falling edge on the line starts a local count. The start bit is then checked again at the middle of the bit. A line that has gone high by that point is treated as noise, and the frame is dropped. In the undivided mode, every strobe samples one bit and the start bit is not checked a second time.

The frame format is chosen at run time by static configuration inputs:
- 7 or 8 data bits, sent least-significant bit first;
- no parity, even parity or odd parity;
- one or two stop bits.

A finished word goes into a holding register and raises a ready flag. The holding register also keeps two flags that describe that word: a framing error and a parity error. A third flag reports overrun, which means a word was lost because the previous word had not yet been taken. The consumer takes a word by pulsing an acknowledge input.

Top module: `serial_rx_engine`

## Requirements
- R1: After a synchronous reset, `rx_data` is 0 and `data_rdy`, `err_frame`, `err_parity` and `err_overrun` are all 0.
- R2: With division by 16 or 64 (N), a strobe that samples the line low after a high sample marks the start. The start bit is sampled N/2 strobes after that strobe. Every later bit is sampled N strobes after the previous sample.
- R3: In a divided mode, if the start bit is sampled high at its midpoint, the frame is abandoned. No word is delivered, and the next falling edge starts a new frame.
- R4: With division by 1, the first strobe in idle that samples the line low is taken as the start bit. Each following strobe samples exactly one bit.
- R5: When `cfg_par_en` is 1, one parity bit follows the data. `err_parity` is 1 for the delivered word when the data bits plus the parity bit hold an odd count of ones under even parity (`cfg_par_odd`=0), or an even count under odd parity (`cfg_par_odd`=1).
- R6: `err_frame` is 1 for the delivered word exactly when its first stop bit was sampled low.
- R7: Data arrives least-significant bit first. When `cfg_word8` is 0, seven bits are received and `rx_data[7]` reads 0.
- R8: `data_rdy` rises in the clock cycle that samples the final stop bit. It is cleared by a one-cycle `rd_ack`.
- R9: If a word completes while `data_rdy` is 1 and `rd_ack` is 0, the new word is discarded and `err_overrun` is set. `rx_data`, `err_frame` and `err_parity` keep their values. `rd_ack` clears `err_overrun`.
- R10: When `cfg_stop2` is 1, the word completes at the sample of the second stop bit. The level of that second stop bit is ignored.
- R11: If `rd_ack` arrives in the same cycle as a word completes, the new word is loaded, `data_rdy` stays 1 and `err_overrun` is 0.
- R12: The divide setting `cfg_div` is encoded as 0 for divide-by-1, 1 for divide-by-16, and 2 or 3 for divide-by-64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | One-cycle strobe marking a receive-clock rising edge |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_div | input | 2 | Divide select: 0 = /1, 1 = /16, 2 or 3 = /64 |
| cfg_word8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfg_par_en | input | 1 | 1 = parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| rd_ack | input | 1 | One-cycle pulse that takes the held word |
| rx_data | output | 8 | Held received word |
| data_rdy | output | 1 | A word is waiting in the holding register |
| err_frame | output | 1 | The held word had a low first stop bit |
| err_parity | output | 1 | The held word failed its parity check |
| err_overrun | output | 1 | A word was lost while the holding register was full |

## Verification
The two functions that can land in the same clock cycle are completion of a new word and the consumer's acknowledge of the old word. The bench provokes this by raising `rd_ack` together with the strobe that samples the final stop bit, while an earlier word is still held. It then judges that the second word is present, that ready stays set and that no overrun is reported. The same clock-by-clock model also covers the opposite case: two words back to back with no acknowledge must raise overrun and keep the first word.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [1:0] div;
    logic       word8;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } rx_cfg_t;

  localparam logic [1:0] DIV_ONE = 2'd0;
  localparam logic [1:0] DIV_MID = 2'd1;

endpackage

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int MID_DIV  = 16,
  parameter int SLOW_DIV = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_en,
  input  logic [1:0] div,
  input  logic       restart,
  input  logic       half,
  output logic       samp
);
  import serial_rx_pkg::*;

  localparam int CW = $clog2(SLOW_DIV) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] nxt;
  logic [CW-1:0] target;

  // Number of strobes between samples for the selected mode.
  // In the start state only half a bit period is counted.
  always_comb begin
    case (div)
      DIV_ONE: target = CW'(1);
      DIV_MID: target = half ? CW'(MID_DIV / 2) : CW'(MID_DIV);
      default: target = half ? CW'(SLOW_DIV / 2) : CW'(SLOW_DIV);
    endcase
    nxt  = cnt + CW'(1);
    samp = rx_en && ((div == DIV_ONE) || (nxt == target));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (rx_en) begin
      if (restart || samp) cnt <= '0;
      else                 cnt <= nxt;
    end
  end

  // R2: the strobe count never exceeds the longest bit period
  a_r2_cnt_in_period: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(SLOW_DIV));

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm #(
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rx_en,
  input  logic                   rxd,
  input  logic                   samp,
  input  serial_rx_pkg::rx_cfg_t cfg,
  output logic                   restart,
  output logic                   half,
  output logic                   done,
  output logic [DATA_W-1:0]      word,
  output logic                   fe,
  output logic                   pe
);
  import serial_rx_pkg::*;

  localparam int BW = $clog2(DATA_W);

  rx_state_e         state;
  logic              prev_rx;
  logic [DATA_W-1:0] sh;
  logic [BW-1:0]     bitn;
  logic [BW-1:0]     last_bit;
  logic              par_bit;
  logic              fe_q;
  logic              fall;

  assign fall     = rx_en && prev_rx && !rxd;
  assign last_bit = cfg.word8 ? BW'(DATA_W - 1) : BW'(DATA_W - 2);
  assign restart  = (state == ST_IDLE) && fall && (cfg.div != DIV_ONE);
  assign half     = (state == ST_START);

  // Short words sit in the upper bits of the shifter, so they are
  // moved down by one place and the top bit is filled with 0 (R7).
  always_comb begin
    word = cfg.word8 ? sh : {1'b0, sh[DATA_W-1:1]};
    pe   = cfg.par_en && ((^word ^ par_bit) != cfg.par_odd);
    done = samp && (((state == ST_STOP1) && !cfg.stop2) || (state == ST_STOP2));
    fe   = (state == ST_STOP2) ? fe_q : !rxd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      prev_rx <= 1'b1;
      sh      <= '0;
      bitn    <= '0;
      par_bit <= 1'b0;
      fe_q    <= 1'b0;
    end else begin
      if (rx_en) prev_rx <= rxd;
      case (state)
        ST_IDLE: begin
          bitn <= '0;
          if (cfg.div == DIV_ONE) begin
            if (samp && !rxd) state <= ST_DATA;
          end else if (fall) begin
            state <= ST_START;
          end
        end
        ST_START: if (samp) state <= rxd ? ST_IDLE : ST_DATA;
        ST_DATA: if (samp) begin
          sh <= {rxd, sh[DATA_W-1:1]};
          if (bitn == last_bit) state <= cfg.par_en ? ST_PAR : ST_STOP1;
          else                  bitn  <= bitn + BW'(1);
        end
        ST_PAR: if (samp) begin
          par_bit <= rxd;
          state   <= ST_STOP1;
        end
        ST_STOP1: if (samp) begin
          fe_q  <= !rxd;
          state <= cfg.stop2 ? ST_STOP2 : ST_IDLE;
        end
        ST_STOP2: if (samp) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a start bit found high at its midpoint returns the receiver to idle
  a_r3_false_start_abort: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && samp && rxd) |=> (state == ST_IDLE));

  // R10: no word completes at the first stop bit when two are configured
  a_r10_wait_second_stop: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOP1 && samp && cfg.stop2) |=> (state == ST_STOP2));

endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] word,
  input  logic              fe_in,
  input  logic              pe_in,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] data,
  output logic              rdy,
  output logic              fe,
  output logic              pe,
  output logic              ovr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      rdy  <= 1'b0;
      fe   <= 1'b0;
      pe   <= 1'b0;
      ovr  <= 1'b0;
    end else if (done && rdy && !rd_ack) begin
      ovr <= 1'b1;
    end else if (done) begin
      data <= word;
      fe   <= fe_in;
      pe   <= pe_in;
      rdy  <= 1'b1;
      ovr  <= 1'b0;
    end else if (rd_ack) begin
      rdy <= 1'b0;
      ovr <= 1'b0;
    end
  end

  // R9: overrun is only reported while a word is held
  a_r9_ovr_with_rdy: assert property (@(posedge clk) disable iff (rst)
    ovr |-> rdy);

  // R9: a held, unacknowledged word is never disturbed
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (rdy && !rd_ack) |=> ($stable(data) && $stable(fe) && $stable(pe)));

  // R8: an acknowledge without a new word empties the register
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && !done) |=> (!rdy && !ovr));

  // R11: acknowledge together with completion keeps ready and drops overrun
  a_r11_ack_and_done: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && done) |=> (rdy && !ovr));

endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine #(
  parameter int DATA_W   = 8,
  parameter int MID_DIV  = 16,
  parameter int SLOW_DIV = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              rxd,
  input  logic [1:0]        cfg_div,
  input  logic              cfg_word8,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              data_rdy,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun
);
  import serial_rx_pkg::*;

  rx_cfg_t           cfg;
  logic              samp;
  logic              restart;
  logic              half;
  logic              done;
  logic [DATA_W-1:0] word;
  logic              fe_w;
  logic              pe_w;

  assign cfg = '{div: cfg_div, word8: cfg_word8, par_en: cfg_par_en,
                 par_odd: cfg_par_odd, stop2: cfg_stop2};

  rx_bit_timer #(.MID_DIV(MID_DIV), .SLOW_DIV(SLOW_DIV)) timer_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .div(cfg_div),
    .restart(restart), .half(half), .samp(samp)
  );

  rx_frame_fsm #(.DATA_W(DATA_W)) fsm_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rxd(rxd), .samp(samp),
    .cfg(cfg), .restart(restart), .half(half), .done(done),
    .word(word), .fe(fe_w), .pe(pe_w)
  );

  rx_hold_reg #(.DATA_W(DATA_W)) hold_i (
    .clk(clk), .rst(rst), .done(done), .word(word), .fe_in(fe_w),
    .pe_in(pe_w), .rd_ack(rd_ack), .data(rx_data), .rdy(data_rdy),
    .fe(err_frame), .pe(err_parity), .ovr(err_overrun)
  );

endmodule

// File: tb/serial_rx_engine_tb_top.sv
module serial_rx_engine_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_div = 2'd1;
  logic       cfg_word8 = 1'b1;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_stop2 = 1'b0;
  logic       rd_ack = 1'b0;
  logic [7:0] rx_data;
  logic       data_rdy, err_frame, err_parity, err_overrun;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  serial_rx_engine dut_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rxd(rxd), .cfg_div(cfg_div),
    .cfg_word8(cfg_word8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .rd_ack(rd_ack), .rx_data(rx_data),
    .data_rdy(data_rdy), .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun)
  );

  // ---------------- behavioural reference model ----------------
  int   m_phase;      // 0 idle, 1 verifying start, 2 collecting bits
  int   m_ev;
  bit   m_prev;
  bit   m_q[$];
  logic [7:0] e_data;
  bit   e_rdy, e_fe, e_pe, e_ovr;

  function automatic int div_n(logic [1:0] d);
    return (d == 2'd0) ? 1 : (d == 2'd1) ? 16 : 64;
  endfunction

  always @(posedge clk) begin
    bit fin;
    logic [7:0] fw;
    bit ffe, fpe;
    int nb, need, ones, n;
    fin = 0; fw = '0; ffe = 0; fpe = 0;
    if (rst) begin
      m_phase = 0; m_ev = 0; m_prev = 1; m_q.delete();
      e_data = '0; e_rdy = 0; e_fe = 0; e_pe = 0; e_ovr = 0;
    end else begin
      if (rx_en) begin
        n    = div_n(cfg_div);
        nb   = cfg_word8 ? 8 : 7;
        need = nb + (cfg_par_en ? 1 : 0) + (cfg_stop2 ? 2 : 1);
        if (m_phase == 0) begin
          if (n == 1) begin
            if (!rxd) begin m_phase = 2; m_q.delete(); end
          end else if (m_prev && !rxd) begin
            m_phase = 1; m_ev = 0;
          end
        end else if (m_phase == 1) begin
          m_ev++;
          if (m_ev == n / 2) begin
            m_ev = 0;
            if (rxd) m_phase = 0;
            else begin m_phase = 2; m_q.delete(); end
          end
        end else begin
          bit take;
          take = 0;
          if (n == 1) take = 1;
          else begin
            m_ev++;
            if (m_ev == n) begin m_ev = 0; take = 1; end
          end
          if (take) begin
            m_q.push_back(rxd);
            if (m_q.size() == need) begin
              fin = 1; ones = 0;
              for (int i = 0; i < nb; i++) begin
                fw[i] = m_q[i];
                ones += m_q[i];
              end
              if (cfg_par_en) fpe = (((ones + m_q[nb]) % 2) == 1) != cfg_par_odd;
              ffe = (m_q[nb + (cfg_par_en ? 1 : 0)] == 0);
              m_phase = 0;
            end
          end
        end
        m_prev = rxd;
      end
      if (fin && e_rdy && !rd_ack) e_ovr = 1;
      else if (fin) begin
        e_data = fw; e_fe = ffe; e_pe = fpe; e_rdy = 1; e_ovr = 0;
      end else if (rd_ack) begin
        e_rdy = 0; e_ovr = 0;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Clock-by-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (!finished) begin
      chk("R7 rx_data vs model", rx_data, e_data);
      chk("R8 data_rdy vs model", data_rdy, e_rdy);
      chk("R6 err_frame vs model", err_frame, e_fe);
      chk("R5 err_parity vs model", err_parity, e_pe);
      chk("R9 err_overrun vs model", err_overrun, e_ovr);
    end
  end

  // ---------------- stimulus ----------------
  task automatic ev(bit v, bit a);
    @(negedge clk);
    rxd = v; rx_en = 1'b1; rd_ack = a;
    @(negedge clk);
    rx_en = 1'b0; rd_ack = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); rd_ack = 1'b1;
    @(negedge clk); rd_ack = 1'b0;
  endtask

  task automatic send(logic [1:0] dv, logic [7:0] d, bit w8, bit pen, bit podd,
                      bit st2, bit badp, bit s1, bit s2, bit ack_end);
    bit bits[$];
    int n, nb, ones, idx;
    bit p;
    cfg_div = dv; cfg_word8 = w8; cfg_par_en = pen;
    cfg_par_odd = podd; cfg_stop2 = st2;
    n = div_n(dv); nb = w8 ? 8 : 7; ones = 0;
    bits.push_back(1'b0);
    for (int i = 0; i < nb; i++) begin bits.push_back(d[i]); ones += d[i]; end
    if (pen) begin
      p = ((ones % 2) == 1) ^ podd;
      bits.push_back(p ^ badp);
    end
    bits.push_back(s1);
    if (st2) bits.push_back(s2);
    idx = (n == 1) ? 0 : n / 2;
    for (int b = 0; b < bits.size(); b++)
      for (int k = 0; k < n; k++)
        ev(bits[b], ack_end && (b == bits.size() - 1) && (k == idx));
    for (int k = 0; k < ((n == 1) ? 3 : n + 2); k++) ev(1'b1, 1'b0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 data after reset", rx_data, 0);
    chk("R1 rdy after reset", {data_rdy, err_frame, err_parity, err_overrun}, 0);

    // R2: divide-by-16, 8 bits, no parity
    send(2'd1, 8'hA5, 1, 0, 0, 0, 0, 1, 1, 0);
    chk("R2 div16 data", rx_data, 8'hA5);
    chk("R8 ready set", data_rdy, 1);
    ack(); @(negedge clk);
    chk("R8 ready cleared by ack", data_rdy, 0);

    // R12: code 3 acts as divide-by-64; 7 bits with good even parity
    send(2'd3, 8'h35, 0, 1, 0, 0, 0, 1, 1, 0);
    chk("R12 div64 data", rx_data, 8'h35);
    chk("R5 good parity", err_parity, 0);
    ack();

    // R4 and R10: divide-by-1, odd parity, two stop bits, second stop low
    send(2'd0, 8'h3C, 1, 1, 1, 1, 0, 1, 0, 0);
    chk("R4 div1 data", rx_data, 8'h3C);
    chk("R10 second stop ignored", err_frame, 0);
    ack();

    // R5: bad even parity
    send(2'd1, 8'h5A, 1, 1, 0, 0, 1, 1, 1, 0);
    chk("R5 parity error", err_parity, 1);
    ack();

    // R6 and R7: 7-bit word of all ones with low stop bit
    send(2'd1, 8'hFF, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R7 msb zero in 7-bit", rx_data, 8'h7F);
    chk("R6 framing error", err_frame, 1);
    ack();

    // R3: false start at divide-by-16
    cfg_div = 2'd1;
    for (int k = 0; k < 3; k++) ev(1'b0, 1'b0);
    for (int k = 0; k < 40; k++) ev(1'b1, 1'b0);
    chk("R3 no word after glitch", data_rdy, 0);
    send(2'd1, 8'h11, 1, 0, 0, 0, 0, 1, 1, 0);
    chk("R3 receiver recovers", rx_data, 8'h11);
    ack();

    // R9: overrun at divide-by-1
    send(2'd0, 8'h22, 1, 0, 0, 0, 0, 1, 1, 0);
    send(2'd0, 8'h33, 1, 0, 0, 0, 0, 1, 1, 0);
    chk("R9 first word kept", rx_data, 8'h22);
    chk("R9 overrun set", err_overrun, 1);
    ack(); @(negedge clk);
    chk("R9 overrun cleared", err_overrun, 0);

    // R11: acknowledge in the completion cycle
    send(2'd1, 8'h44, 1, 0, 0, 0, 0, 1, 1, 0);
    send(2'd1, 8'h55, 1, 0, 0, 0, 0, 1, 1, 1);
    chk("R11 new word loaded", rx_data, 8'h55);
    chk("R11 ready kept, no overrun", {data_rdy, err_overrun}, 2'b10);
    ack();
    repeat (4) @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule